// File: doc/BRIEF.md
# Fractional-N Divide-Word Modulator

This block produces the feedback divide value of a fractional-N synthesizer once per reference clock. It takes a 15-bit channel word, an 8-bit deviation word, a band flag, a modulation-type flag and the transmit data bit. From these it builds a fixed-point divide ratio. The ratio has an integer base of 24 or 32.5, a numerator in units of 1/16384 and a permanent half-unit offset.

A second-order cascade of two first-order accumulators then dithers the integer divide value around that ratio. Its long-run mean equals the ratio exactly. The analog loop counts the feedback clock with the integer it receives. Changing the data bit moves the loop between the two keying frequencies without clearing the dither state.

Input words outside their legal ranges are pulled to the nearest legal bound, and a flag reports that this happened. The configuration is registered once per reference cycle. An input change therefore reaches the divide output on the second clock edge after it is applied.

Top module: `fnmod_divword`

## Requirements
- R1: With `band_hi_i` = 0 the ratio is 24 + (F + O + 0.5)/16384. Here F is the clamped channel word and O is the offset chosen by R3/R4. Internally this is 24 + (2·(F+O)+1)/32768.
- R2: With `band_hi_i` = 1 the base is 32.5 instead of 24, with the same numerator term.
- R3: With `ask_mode_i` = 0 (frequency keying), `tx_bit_i` = 1 gives O = D, where D is the clamped deviation word, and `tx_bit_i` = 0 gives O = 0.
- R4: With `ask_mode_i` = 1 (amplitude keying), O = floor(D/2), so an odd D drops its half. In this mode `tx_bit_i` has no effect on the divide sequence.
- R5: A channel word below 2500 is used as 2500, and one above 22000 is used as 22000. In either case `cfg_err_o` is 1 from the first clock edge after the word is applied.
- R6: A deviation word of 0 is used as 1 and sets `cfg_err_o`. Any deviation word from 1 to 255 leaves the flag clear, provided the channel word is also legal.
- R7: Every valid output lies between N−1 and N+2, where N is the integer part of the current ratio.
- R8: From reset, the sum of the first k valid outputs equals k·N + floor(k·f/32768) or that value plus one, where f is the fractional part of the ratio in 1/32768 units.
- R9: An input change applied between edges reaches `div_o` at the second edge after it is applied. The accumulators are not cleared. Over any later window of k outputs, the sum stays within [k·N + floor(k·f/32768) − 1, k·N + floor(k·f/32768) + 2].
- R10: During reset `div_o`, `div_vld_o` and `cfg_err_o` are 0. After reset is released, `div_vld_o` stays 0 after the first edge and is 1 from the second edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one divide value per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word_i | input | 15 | Channel word, numerator LSB = 1/16384 |
| dev_word_i | input | 8 | Deviation word |
| band_hi_i | input | 1 | 1 selects base 32.5, 0 selects base 24 |
| ask_mode_i | input | 1 | 1 selects amplitude keying, 0 frequency keying |
| tx_bit_i | input | 1 | Transmit data bit |
| div_o | output | 7 | Integer feedback divide value |
| div_vld_o | output | 1 | High when `div_o` carries a modulated value |
| cfg_err_o | output | 1 | A word was clamped in the last sampled configuration |

## Verification
The bench builds the block with its default parameters: a 15-bit fraction, a second-order modulator and a 7-bit divide output. With these defaults the fractional period is 32768 cycles, so a run of two full periods fits in the cycle budget. Over two periods the sum of outputs pins the programmed ratio to a single 1/32768 step, which exposes an error in the half-unit offset, the half base or the rounding of the amplitude-keying offset. Shorter windows after mid-run changes, with random words that include out-of-range values, exercise clamping and confirm that the accumulator state carries across configuration changes.

// File: rtl/fnmod_pkg.sv
package fnmod_pkg;

   // Which deviation-derived term is added to the channel word
   typedef enum logic [1:0] {
      OFS_NONE = 2'd0,
      OFS_FULL = 2'd1,
      OFS_HALF = 2'd2
   } ofs_sel_e;

   function automatic ofs_sel_e pick_offset(input logic ask, input logic tx);
      if (ask)     return OFS_HALF;
      else if (tx) return OFS_FULL;
      else         return OFS_NONE;
   endfunction

endpackage

// File: rtl/fnmod_clamp.sv
module fnmod_clamp #(
   parameter int W  = 15,
   parameter int LO = 2500,
   parameter int HI = 22000
) (
   input  logic [W-1:0] val_i,
   output logic [W-1:0] val_o,
   output logic         err_o
);
   localparam logic [W-1:0] LO_V = W'(LO);
   localparam logic [W-1:0] HI_V = W'(HI);

   if (LO > HI || HI >= (2 ** W) || LO < 0) begin : g_bad_bounds
      $error("fnmod_clamp: bounds do not fit the word width");
   end

   always_comb begin
      if (val_i < LO_V) begin
         val_o = LO_V;
         err_o = 1'b1;
      end else if (val_i > HI_V) begin
         val_o = HI_V;
         err_o = 1'b1;
      end else begin
         val_o = val_i;
         err_o = 1'b0;
      end
   end
endmodule

// File: rtl/fnmod_ratio.sv
module fnmod_ratio
   import fnmod_pkg::*;
#(
   parameter int FREQ_W     = 15,
   parameter int DEV_W      = 8,
   parameter int FRAC_W     = 15,
   parameter int NUM_FRAC_W = 14,
   parameter int DIV_W      = 7,
   parameter int LO_BASE    = 24,
   parameter int HI_BASE    = 32,
   parameter int FREQ_MIN   = 2500,
   parameter int FREQ_MAX   = 22000,
   parameter int DEV_MIN    = 1,
   parameter int DEV_MAX    = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [DEV_W-1:0]  dev_i,
   input  logic              freq_err_i,
   input  logic              dev_err_i,
   input  logic              band_hi_i,
   input  logic              ask_i,
   input  logic              tx_i,
   output logic [DIV_W-1:0]  intg_q,
   output logic [FRAC_W-1:0] frac_q,
   output logic              vld_q,
   output logic              err_q
);
   localparam int STEP_SH   = FRAC_W - NUM_FRAC_W;
   localparam int SUM_W     = FRAC_W + 2;
   localparam int NUM_W     = FREQ_W + 1;
   localparam int HALF_LSB  = (STEP_SH >= 1) ? (1 << (STEP_SH - 1)) : 0;
   localparam int HALF_BASE = 1 << (FRAC_W - 1);
   localparam int SUM_MAX   = ((FREQ_MAX + DEV_MAX) << STEP_SH) + HALF_LSB + HALF_BASE;

   if (STEP_SH < 1) begin : g_bad_step
      $error("fnmod_ratio: fraction must be wider than the numerator step");
   end
   if (SUM_MAX >= (2 ** SUM_W)) begin : g_bad_sum
      $error("fnmod_ratio: fraction sum overflows");
   end
   if (FREQ_MAX + DEV_MAX >= (2 ** NUM_W)) begin : g_bad_num
      $error("fnmod_ratio: numerator overflows");
   end
   if (HI_BASE + 4 >= (2 ** DIV_W) || LO_BASE < 2) begin : g_bad_div
      $error("fnmod_ratio: divide width cannot hold the base range");
   end

   ofs_sel_e           sel;
   logic [DEV_W-1:0]   ofs;
   logic [NUM_W-1:0]   numer;
   logic [SUM_W-1:0]   sum;
   logic [DIV_W-1:0]   intg_d;

   always_comb begin
      sel = pick_offset(ask_i, tx_i);
      unique case (sel)
         OFS_FULL: ofs = dev_i;
         OFS_HALF: ofs = dev_i >> 1;
         default:  ofs = '0;
      endcase
      numer  = {1'b0, freq_i} + NUM_W'(ofs);
      sum    = (SUM_W'(numer) << STEP_SH) + SUM_W'(HALF_LSB)
             + (band_hi_i ? SUM_W'(HALF_BASE) : SUM_W'(0));
      intg_d = (band_hi_i ? DIV_W'(HI_BASE) : DIV_W'(LO_BASE))
             + DIV_W'(sum[SUM_W-1:FRAC_W]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         intg_q <= '0;
         frac_q <= '0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         intg_q <= intg_d;
         frac_q <= sum[FRAC_W-1:0];
         vld_q  <= 1'b1;
         err_q  <= freq_err_i | dev_err_i;
      end
   end

   // R5
   freq_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_i >= FREQ_W'(FREQ_MIN)) && (freq_i <= FREQ_W'(FREQ_MAX)));
   // R6
   dev_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_i >= DEV_W'(DEV_MIN)) && (dev_i <= DEV_W'(DEV_MAX)));
   // R5
   err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_err_i || dev_err_i) |=> err_q);
endmodule

// File: rtl/fnmod_mash.sv
module fnmod_mash #(
   parameter int FRAC_W = 15,
   parameter int DIV_W  = 7,
   parameter int ORDER  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic [DIV_W-1:0]  intg_i,
   input  logic [FRAC_W-1:0] frac_i,
   output logic [DIV_W-1:0]  div_q,
   output logic              vld_q
);
   localparam int TOT_W = DIV_W + 2;

   if (ORDER != 1 && ORDER != 2) begin : g_bad_order
      $error("fnmod_mash: only first and second order are provided");
   end

   logic [FRAC_W:0]    s1;
   logic [FRAC_W-1:0]  acc1;
   logic               c1;
   logic [TOT_W-1:0]   tot;

   always_comb begin
      s1 = {1'b0, acc1} + {1'b0, frac_i};
      c1 = s1[FRAC_W];
   end

   if (ORDER == 2) begin : g_o2
      logic [FRAC_W:0]   s2;
      logic [FRAC_W-1:0] acc2;
      logic              c2;
      logic              c2_prev;

      always_comb begin
         s2  = {1'b0, acc2} + {1'b0, s1[FRAC_W-1:0]};
         c2  = s2[FRAC_W];
         tot = {2'b00, intg_i} + TOT_W'(c1) + TOT_W'(c2) - TOT_W'(c2_prev);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc2    <= '0;
            c2_prev <= 1'b0;
         end else if (en_i) begin
            acc2    <= s2[FRAC_W-1:0];
            c2_prev <= c2;
         end
      end
   end else begin : g_o1
      always_comb begin
         tot = {2'b00, intg_i} + TOT_W'(c1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc1  <= '0;
         div_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= en_i;
         if (en_i) begin
            acc1  <= s1[FRAC_W-1:0];
            div_q <= tot[DIV_W-1:0];
         end
      end
   end

   // R7
   div_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ((int'(div_q) + 1 >= int'($past(intg_i)))
              && (int'(div_q) <= int'($past(intg_i)) + 2)));
   // R10
   vld_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(en_i));
endmodule

// File: rtl/fnmod_divword.sv
module fnmod_divword #(
   parameter int FREQ_W     = 15,
   parameter int DEV_W      = 8,
   parameter int FRAC_W     = 15,
   parameter int NUM_FRAC_W = 14,
   parameter int DIV_W      = 7,
   parameter int LO_BASE    = 24,
   parameter int HI_BASE    = 32,
   parameter int FREQ_MIN   = 2500,
   parameter int FREQ_MAX   = 22000,
   parameter int DEV_MIN    = 1,
   parameter int DEV_MAX    = 255,
   parameter int ORDER      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FREQ_W-1:0] freq_word_i,
   input  logic [DEV_W-1:0]  dev_word_i,
   input  logic              band_hi_i,
   input  logic              ask_mode_i,
   input  logic              tx_bit_i,
   output logic [DIV_W-1:0]  div_o,
   output logic              div_vld_o,
   output logic              cfg_err_o
);
   logic [FREQ_W-1:0] freq_c;
   logic [DEV_W-1:0]  dev_c;
   logic              freq_err;
   logic              dev_err;
   logic [DIV_W-1:0]  intg_q;
   logic [FRAC_W-1:0] frac_q;
   logic              cfg_vld;

   fnmod_clamp #(.W(FREQ_W), .LO(FREQ_MIN), .HI(FREQ_MAX)) u_freq_clamp (
      .val_i (freq_word_i),
      .val_o (freq_c),
      .err_o (freq_err)
   );

   fnmod_clamp #(.W(DEV_W), .LO(DEV_MIN), .HI(DEV_MAX)) u_dev_clamp (
      .val_i (dev_word_i),
      .val_o (dev_c),
      .err_o (dev_err)
   );

   fnmod_ratio #(
      .FREQ_W(FREQ_W), .DEV_W(DEV_W), .FRAC_W(FRAC_W), .NUM_FRAC_W(NUM_FRAC_W),
      .DIV_W(DIV_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE),
      .FREQ_MIN(FREQ_MIN), .FREQ_MAX(FREQ_MAX), .DEV_MIN(DEV_MIN), .DEV_MAX(DEV_MAX)
   ) u_ratio (
      .clk        (clk),
      .rst_n      (rst_n),
      .freq_i     (freq_c),
      .dev_i      (dev_c),
      .freq_err_i (freq_err),
      .dev_err_i  (dev_err),
      .band_hi_i  (band_hi_i),
      .ask_i      (ask_mode_i),
      .tx_i       (tx_bit_i),
      .intg_q     (intg_q),
      .frac_q     (frac_q),
      .vld_q      (cfg_vld),
      .err_q      (cfg_err_o)
   );

   fnmod_mash #(.FRAC_W(FRAC_W), .DIV_W(DIV_W), .ORDER(ORDER)) u_mash (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (cfg_vld),
      .intg_i (intg_q),
      .frac_i (frac_q),
      .div_q  (div_o),
      .vld_q  (div_vld_o)
   );
endmodule

// File: tb/fnmod_divword_bench.sv
module fnmod_divword_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] freq_w = 15'd3730;
   logic [7:0]  dev_w = 8'd100;
   logic        band = 1'b0;
   logic        ask = 1'b0;
   logic        tx = 1'b0;
   logic [6:0]  div;
   logic        div_vld;
   logic        cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   int rec [200];

   always #5 clk = ~clk;

   fnmod_divword u_fnmod_divword (
      .clk(clk), .rst_n(rst_n), .freq_word_i(freq_w), .dev_word_i(dev_w),
      .band_hi_i(band), .ask_mode_i(ask), .tx_bit_i(tx),
      .div_o(div), .div_vld_o(div_vld), .cfg_err_o(cfg_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ratio_units(input int fr, input int fs, input bit b,
                                          input bit a, input bit t);
      int f = (fr < 2500) ? 2500 : (fr > 22000) ? 22000 : fr;
      int d = (fs < 1) ? 1 : fs;
      int o = a ? (d / 2) : (t ? d : 0);
      return (b ? 32 : 24) * 64'd32768 + (b ? 16384 : 0) + 2 * (f + o) + 1;
   endfunction

   function automatic bit exp_err(input int fr, input int fs);
      return (fr < 2500) || (fr > 22000) || (fs < 1);
   endfunction

   task automatic set_cfg(input int fr, input int fs, input bit b, input bit a, input bit t);
      freq_w = 15'(fr); dev_w = 8'(fs); band = b; ask = a; tx = t;
   endtask

   // leaves the bench at the negedge right after reset release
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // accumulates k consecutive outputs from the next negedge on
   task automatic run_win(input int k, input bit exact, input string req, input string rreq);
      longint t = ratio_units(int'(freq_w), int'(dev_w), band, ask, tx);
      longint n = t >> 15;
      longint f = t & 64'd32767;
      longint sum = 0;
      longint base;
      int bad = 0;
      longint lo, hi;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (!div_vld || longint'(div) < n - 1 || longint'(div) > n + 2) bad++;
         sum += longint'(div);
      end
      base = longint'(k) * n + (longint'(k) * f) / 32768;
      lo = exact ? base : base - 1;
      hi = exact ? base + 1 : base + 2;
      chk(bad == 0, rreq, bad, 0);
      chk(sum >= lo && sum <= hi, req, sum, base);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      // R10 reset state
      set_cfg(14342, 100, 1'b1, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      chk(div == 0 && !div_vld && !cfg_err, "R10 reset", {div_vld, div}, 0);
      do_reset();
      @(negedge clk);
      chk(!div_vld, "R10 first edge", div_vld, 0);
      // R2 R3 R8 exact over two periods, high band, upper keying frequency
      run_win(65536, 1'b1, "R2_R3_R8", "R7");

      // R1 R4 R8: low band, amplitude keying, odd deviation loses its half
      set_cfg(3730, 101, 1'b0, 1'b1, 1'b0);
      do_reset();
      @(negedge clk);
      run_win(65536, 1'b1, "R1_R4_R8", "R7");

      // R4 data bit ignored in amplitude keying
      set_cfg(9000, 77, 1'b1, 1'b1, 1'b0);
      do_reset();
      @(negedge clk);
      for (int i = 0; i < 200; i++) begin @(negedge clk); rec[i] = int'(div); end
      do_reset();
      @(negedge clk);
      begin
         int mism = 0;
         for (int i = 0; i < 200; i++) begin
            tx = 1'($urandom_range(0, 1));
            @(negedge clk);
            if (int'(div) != rec[i]) mism++;
         end
         chk(mism == 0, "R4 tx ignored", mism, 0);
      end

      // R3 lower keying frequency uses channel word alone
      set_cfg(6000, 200, 1'b0, 1'b0, 1'b0);
      do_reset();
      @(negedge clk);
      run_win(4096, 1'b1, "R3 low tone", "R7");

      // R5 clamping of the channel word
      set_cfg(100, 50, 1'b0, 1'b0, 1'b1);
      do_reset();
      @(negedge clk);
      chk(cfg_err, "R5 low flag", cfg_err, 1);
      run_win(4096, 1'b1, "R5 low clamp", "R7");
      set_cfg(30000, 50, 1'b1, 1'b0, 1'b0);
      do_reset();
      @(negedge clk);
      chk(cfg_err, "R5 high flag", cfg_err, 1);
      run_win(4096, 1'b1, "R5 high clamp", "R7");

      // R6 deviation clamping and the legal top value
      set_cfg(12000, 0, 1'b0, 1'b0, 1'b1);
      do_reset();
      @(negedge clk);
      chk(cfg_err, "R6 zero flag", cfg_err, 1);
      run_win(4096, 1'b1, "R6 zero clamp", "R7");
      set_cfg(12000, 255, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk(!cfg_err, "R6 max legal", cfg_err, 0);

      // R9 mid-run changes without reset, random words
      for (int r = 0; r < 20; r++) begin
         int fr = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 32767))
                                                 : int'($urandom_range(2500, 22000));
         int fs = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 255));
         set_cfg(fr, fs, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));
         @(negedge clk);
         chk(cfg_err == exp_err(fr, fs), "R5_R6 random flag", cfg_err, exp_err(fr, fs));
         run_win(256, 1'b0, "R9 window", "R7");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule